// File: doc/BRIEF.md
# Dual-Bank Reference Code Register File

This block holds the digital codes for eighteen reference output channels. Sixteen channels set gamma reference levels and two set common-voltage levels. Each code is 10 bits wide. A byte-wide register write port loads the codes into a volatile working set. That port is the kind a two-wire serial slave front end would drive. All eighteen codes go out in parallel on one flat bus to the downstream converters.

Two emulated nonvolatile banks each hold a complete curve of eighteen codes. A store command copies the whole working set into one bank in a single cycle. A lifetime budget caps the number of store operations. Once the budget is spent, the block refuses every later store and leaves the banks as they are. A bank-select input chooses which stored curve drives the outputs, so the active curve can be switched while the block runs. On a switch, the working set reloads from the newly selected bank, and later edits start from that curve.

Power-on is modelled by the reset: the banks, the working set and the budget counter all clear to zero. Because the working set then matches the selected bank, the load-on-reset behaviour holds trivially.

Top module: `refCodeBank`

## Requirements
- R1: After reset, every code on `codesOut` is 0, `storesLeft` is 16 and `budgetGone` is 0.
- R2: A code is written in two bytes. A byte with `wrIsLow`=0 stages its bits [1:0] as code bits [9:8]. A later byte with `wrIsLow`=1 commits {staged bits, byte} to the channel `wrIdx`. The output does not change until the low byte is committed.
- R3: Channel k appears at `codesOut[k*10 +: 10]`. Indices 0–15 are gamma channels and 16–17 are common-voltage channels. A low byte sent to any index from 18 to 31 changes no code.
- R4: A granted store (`storeReq`=1) copies all eighteen working codes into bank `storeBank` in one cycle. After a store, the outputs show the bank chosen by `bankSel`.
- R5: At most 16 stores are granted over the block's lifetime. A store request after the 16th leaves both banks and the counter unchanged.
- R6: `storesLeft` equals 16 minus the number of granted stores. `budgetGone` is 1 exactly when `storesLeft` is 0.
- R7: Between reset (or the most recent store or bank switch) and the next committed code write, the outputs show the bank that `bankSel` selected at the previous clock edge. Once a code is committed, the outputs show the working set. A change of `bankSel` makes the outputs show the new bank after the next clock edge, and reloads the working set from that bank.
- R8: When a low byte is committed in the same cycle that `bankSel` changes, the write is dropped and the reload takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset (power-on model) |
| wrEn | input | 1 | Byte write strobe |
| wrIsLow | input | 1 | 1: low byte (commits code), 0: high byte (staged) |
| wrIdx | input | 5 | Channel index for a low byte |
| wrByte | input | 8 | Write data byte |
| storeReq | input | 1 | Store working set to a bank |
| storeBank | input | 1 | Target bank of a store |
| bankSel | input | 1 | Bank that drives the outputs |
| codesOut | output | 180 | Eighteen 10-bit codes, channel k at bits k*10+9:k*10 |
| storesLeft | output | 5 | Remaining store budget |
| budgetGone | output | 1 | Store budget exhausted |

## Verification
The following rules are checked on every cycle:
- The counter never passes its cap.
- A refused store leaves the counter alone.
- The exhaustion flag matches the remaining count.
- A granted store lands the previous working codes in the target bank.
- A commit lands in its channel.
- A bank switch reloads the working set and selects bank view.

Other behaviours show only in the bench's scenarios:
- The exact output mapping per channel.
- Half-written codes staying invisible.
- Out-of-range indices being ignored.
- Preservation of a bank across a refused store, which is seen by switching banks back and forth.

// File: rtl/refcode_pkg.sv
package refcode_pkg;
  parameter int NUM_GAMMA  = 16;
  parameter int NUM_VCOM   = 2;
  parameter int CODE_W     = 10;
  parameter int BYTE_W     = 8;
  parameter int NUM_BANKS  = 2;
  parameter int MAX_STORES = 16;
  parameter int IDX_W      = 5;

  localparam int NUM_CH = NUM_GAMMA + NUM_VCOM;
  localparam int HI_W   = CODE_W - BYTE_W;
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int USED_W = $clog2(MAX_STORES + 1);
  localparam int OUT_W  = NUM_CH * CODE_W;

  typedef struct packed {
    logic              latchHigh;
    logic              commit;
    logic [IDX_W-1:0]  idx;
    logic              store;
    logic [BANK_W-1:0] storeBank;
    logic              reload;
    logic [BANK_W-1:0] reloadBank;
    logic [BANK_W-1:0] showBank;
    logic              viewWork;
  } ctrl_t;
endpackage

// File: rtl/refcode_ctrl.sv
module refcode_ctrl
  import refcode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrIsLow,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              storeReq,
  input  logic [BANK_W-1:0] storeBank,
  input  logic [BANK_W-1:0] bankSel,
  output ctrl_t             ctl,
  output logic [USED_W-1:0] storesLeft,
  output logic              budgetGone
);
  logic [BANK_W-1:0] bankSelQ;
  logic [USED_W-1:0] usedCnt;
  logic              viewWorkQ;
  logic              selChange;
  logic              idxOk;
  logic              storeOk;

  assign selChange  = (bankSel != bankSelQ);
  assign idxOk      = (32'(wrIdx) < NUM_CH);
  assign budgetGone = (usedCnt == USED_W'(MAX_STORES));
  assign storeOk    = storeReq && !budgetGone;
  assign storesLeft = USED_W'(MAX_STORES) - usedCnt;

  always_comb begin
    ctl            = '0;
    ctl.latchHigh  = wrEn && !wrIsLow;
    ctl.commit     = wrEn && wrIsLow && idxOk && !selChange;
    ctl.idx        = wrIdx;
    ctl.store      = storeOk;
    ctl.storeBank  = storeBank;
    ctl.reload     = selChange;
    ctl.reloadBank = bankSel;
    ctl.showBank   = bankSelQ;
    ctl.viewWork   = viewWorkQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankSelQ  <= '0;
      usedCnt   <= '0;
      viewWorkQ <= 1'b0;
    end else begin
      bankSelQ <= bankSel;
      if (storeOk) usedCnt <= usedCnt + 1'b1;
      if (selChange || storeOk) viewWorkQ <= 1'b0;
      else if (ctl.commit)      viewWorkQ <= 1'b1;
    end
  end

  // R5: lifetime counter never passes its cap
  assert_budget_cap_R5: assert property (@(posedge clk) disable iff (!rstN)
    usedCnt <= USED_W'(MAX_STORES));
  // R5: a refused store leaves the counter untouched
  assert_refused_store_R5: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq && budgetGone) |=> $stable(usedCnt));
  // R6: status flag agrees with the remaining count
  assert_status_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    budgetGone == (storesLeft == '0));
  // R7: a bank switch shows the new bank on the next cycle
  assert_bank_switch_R7: assert property (@(posedge clk) disable iff (!rstN)
    selChange |=> (!viewWorkQ && bankSelQ == $past(bankSel)));
endmodule

// File: rtl/refcode_datapath.sv
module refcode_datapath
  import refcode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [BYTE_W-1:0] wrByte,
  output logic [OUT_W-1:0]  codesOut
);
  logic [CODE_W-1:0] work    [NUM_CH];
  logic [CODE_W-1:0] bankMem [NUM_BANKS][NUM_CH];
  logic [HI_W-1:0]   stageHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageHi <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        work[c] <= '0;
        for (int b = 0; b < NUM_BANKS; b++) bankMem[b][c] <= '0;
      end
    end else begin
      if (ctl.latchHigh) stageHi <= wrByte[HI_W-1:0];
      if (ctl.reload) begin
        for (int c = 0; c < NUM_CH; c++) work[c] <= bankMem[ctl.reloadBank][c];
      end else if (ctl.commit) begin
        work[ctl.idx] <= {stageHi, wrByte};
      end
      if (ctl.store) begin
        for (int c = 0; c < NUM_CH; c++) bankMem[ctl.storeBank][c] <= work[c];
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_out
    assign codesOut[ch*CODE_W +: CODE_W] =
      ctl.viewWork ? work[ch] : bankMem[ctl.showBank][ch];

    // R4: a granted store lands the previous working code in the target bank
    assert_store_copy_R4: assert property (@(posedge clk) disable iff (!rstN)
      ctl.store |=> bankMem[$past(ctl.storeBank)][ch] == $past(work[ch]));
    // R7: a switch reloads the working code from the chosen bank
    assert_reload_R7: assert property (@(posedge clk) disable iff (!rstN)
      ctl.reload |=> work[ch] == $past(bankMem[ctl.reloadBank][ch]));
  end

  // R2: a committed low byte forms the full code in its channel
  assert_commit_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commit && !ctl.reload) |=> work[$past(ctl.idx)] == $past({stageHi, wrByte}));
endmodule

// File: rtl/refCodeBank.sv
module refCodeBank
  import refcode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrIsLow,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic              storeReq,
  input  logic [BANK_W-1:0] storeBank,
  input  logic [BANK_W-1:0] bankSel,
  output logic [OUT_W-1:0]  codesOut,
  output logic [USED_W-1:0] storesLeft,
  output logic              budgetGone
);
  ctrl_t ctl;

  refcode_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIsLow(wrIsLow), .wrIdx(wrIdx),
    .storeReq(storeReq), .storeBank(storeBank), .bankSel(bankSel),
    .ctl(ctl), .storesLeft(storesLeft), .budgetGone(budgetGone)
  );

  refcode_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrByte(wrByte), .codesOut(codesOut)
  );
endmodule

// File: tb/sim_refCodeBank.sv
module sim_refCodeBank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 18;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrIsLow = 1'b0;
  logic [4:0]  wrIdx = '0;
  logic [7:0]  wrByte = '0;
  logic        storeReq = 1'b0, storeBank = 1'b0, bankSel = 1'b0;
  logic [179:0] codesOut;
  logic [4:0]  storesLeft;
  logic        budgetGone;

  int checks = 0;
  int errors = 0;

  logic [9:0] mWork [NCH];
  logic [9:0] mBank [2][NCH];
  logic [1:0] mStage;
  logic       mView, mSel;
  int         mUsed;

  always #(CLK_PERIOD/2) clk = ~clk;

  refCodeBank u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIsLow(wrIsLow), .wrIdx(wrIdx),
    .wrByte(wrByte), .storeReq(storeReq), .storeBank(storeBank),
    .bankSel(bankSel), .codesOut(codesOut), .storesLeft(storesLeft),
    .budgetGone(budgetGone)
  );

  function automatic logic [9:0] patA(int k);
    return 10'((k * 37 + 5) % 1024);
  endfunction
  function automatic logic [9:0] patB(int k);
    return 10'(1023 - k * 53);
  endfunction

  task automatic checkOut(string req);
    logic [9:0] exp;
    int bad = -1;
    checks++;
    for (int k = 0; k < NCH; k++) begin
      exp = mView ? mWork[k] : mBank[mSel][k];
      if (codesOut[k*10 +: 10] !== exp && bad < 0) begin
        bad = k;
        $display("FAIL %s channel %0d actual %0d expected %0d", req, k,
                 codesOut[k*10 +: 10], exp);
      end
    end
    if (bad >= 0) errors++;
  endtask

  task automatic checkStatus(string req);
    checks++;
    if (storesLeft !== 5'(16 - mUsed) || budgetGone !== (mUsed == 16)) begin
      errors++;
      $display("FAIL %s status actual left=%0d gone=%0d expected left=%0d gone=%0d",
               req, storesLeft, budgetGone, 16 - mUsed, (mUsed == 16));
    end
  endtask

  task automatic sendHigh(logic [1:0] hi);
    @(negedge clk);
    wrEn = 1'b1; wrIsLow = 1'b0; wrByte = {6'd0, hi};
    @(negedge clk);
    wrEn = 1'b0;
    mStage = hi;
  endtask

  task automatic sendLow(int idx, logic [7:0] lo);
    @(negedge clk);
    wrEn = 1'b1; wrIsLow = 1'b1; wrIdx = 5'(idx); wrByte = lo;
    @(negedge clk);
    wrEn = 1'b0;
    if (idx < NCH) begin
      mWork[idx] = {mStage, lo};
      mView = 1'b1;
    end
  endtask

  task automatic writeCode(int idx, logic [9:0] val);
    sendHigh(val[9:8]);
    sendLow(idx, val[7:0]);
  endtask

  task automatic doStore(logic b);
    @(negedge clk);
    storeReq = 1'b1; storeBank = b;
    @(negedge clk);
    storeReq = 1'b0;
    if (mUsed < 16) begin
      for (int k = 0; k < NCH; k++) mBank[b][k] = mWork[k];
      mUsed++;
      mView = 1'b0;
    end
  endtask

  task automatic setSel(logic s);
    @(negedge clk);
    bankSel = s;
    @(negedge clk);
    if (s != mSel) begin
      mSel = s;
      for (int k = 0; k < NCH; k++) mWork[k] = mBank[s][k];
      mView = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NCH; k++) begin
      mWork[k] = '0; mBank[0][k] = '0; mBank[1][k] = '0;
    end
    mStage = '0; mView = 1'b0; mSel = 1'b0; mUsed = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 reset codes");
    checkStatus("R1 reset status");

    // R2/R3: sweep every channel with pattern A
    for (int k = 0; k < NCH; k++) begin
      writeCode(k, patA(k));
      checkOut("R3 channel sweep A");
    end

    // R2: high byte alone must not show on the output
    sendHigh(2'd3);
    checkOut("R2 half code hidden");
    sendLow(4, 8'h5A);
    checkOut("R2 code completed");
    writeCode(4, patA(4));

    // R3: out-of-range indices ignored
    for (int i = NCH; i < 32; i++) begin
      writeCode(i, 10'h3FF);
      checkOut("R3 invalid index ignored");
    end

    // R4: store A to bank 0, view follows bankSel
    doStore(1'b0);
    checkOut("R4 store bank0");
    checkStatus("R6 after first store");

    for (int k = 0; k < NCH; k++) writeCode(k, patB(k));
    checkOut("R7 working view B");
    doStore(1'b1);
    checkOut("R4 store bank1 shows bank0");
    checkStatus("R6 after second store");

    // R7: switch to bank 1, then edit one channel
    setSel(1'b1);
    checkOut("R7 switch to bank1");
    writeCode(5, 10'd77);
    checkOut("R7 edit after reload");

    // R8: write collides with bank switch
    sendHigh(2'd1);
    @(negedge clk);
    wrEn = 1'b1; wrIsLow = 1'b1; wrIdx = 5'd2; wrByte = 8'hC3; bankSel = 1'b0;
    @(negedge clk);
    wrEn = 1'b0;
    mSel = 1'b0; mView = 1'b0;
    for (int k = 0; k < NCH; k++) mWork[k] = mBank[0][k];
    checkOut("R8 write dropped on switch");
    writeCode(1, 10'd500);
    checkOut("R8 later write works");

    // R5/R6: spend the remaining budget
    while (mUsed < 16) begin
      doStore(1'b1);
      checkStatus("R6 budget countdown");
      checkOut("R4 store keeps bank view");
    end

    // R5: refused store leaves bank 0 intact
    writeCode(0, 10'd999);
    doStore(1'b0);
    checkStatus("R5 refused store status");
    checkOut("R5 refused store view");
    setSel(1'b1);
    checkOut("R5 bank1 after exhaustion");
    setSel(1'b0);
    checkOut("R5 bank0 preserved");
    doStore(1'b1);
    checkStatus("R5 second refusal");
    checkOut("R5 second refusal view");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule